// File: doc/BRIEF.md
# Four-Mode Built-In Logic Block Observer Register

This block is an n-bit register meant to stand in for an ordinary pipeline register at the edge of a combinational kernel. Two mode bits choose what the register does on each clock edge. It can act as a plain parallel register, clear itself, or form a serial scan chain. It can also compact the kernel's parallel outputs into a signature as a multiple-input signature register. If its data inputs are held constant in that mode, it acts as a pseudorandom pattern generator for the kernel behind it.

The first stage sits behind a multiplexer. In scan mode it takes the serial input. In signature mode it takes the XOR feedback from a fixed set of taps. The taps come from a primitive polynomial given as a parameter. The last stage always drives the serial output, so several such registers can be chained into one scan path. The mode is sampled on each edge. A mode change acts on the next edge and starts from the contents the register holds at that moment.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst_n` is low, `par_out` is all zeros and `scan_out` is 0.
- R2: With `mode` = 2'b00 (scan), each edge moves stage i-1 into stage i and loads `scan_in` into stage 0.
- R3: `scan_out` always equals the highest stage, `par_out[W-1]`, so a bit entered on `scan_in` appears on `scan_out` after W scan edges.
- R4: With `mode` = 2'b01, one edge clears every stage to zero, whatever `par_in` and `scan_in` carry.
- R5: With `mode` = 2'b10 (signature), stage 0 takes `par_in[0]` XOR the feedback. Stage i>0 takes `par_in[i]` XOR stage i-1. The feedback is the XOR of the stages selected by `TAPS` (default 8'hB8: stages 7, 5, 4 and 3).
- R6: In signature mode with `par_in` held at zero and the default width and taps, a nonzero state first returns to its starting value after exactly 255 edges.
- R7: With `mode` = 2'b11, each edge loads `par_in` into the register unchanged.
- R8: A new mode acts on the very next edge and begins from the current contents. In signature mode, an all-zero state with zero data inputs stays at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Mode select: 00 scan, 01 clear, 10 signature, 11 parallel load |
| par_in | input | W | Parallel data from the kernel |
| scan_in | input | 1 | Serial input to stage 0 in scan mode |
| par_out | output | W | Register contents |
| scan_out | output | 1 | Highest stage, for chaining |

## Verification
Every stage is visible on `par_out`, so a wrong tap, a swapped chain link or a misdecoded mode shows at the ports on the first edge after the faulty update. In signature mode such a fault does not stay put. It spreads through the chain and the feedback, so a single bad bit alters every state that follows. The long pattern-generator run then shows it as a changed period, in addition to the mismatches seen one edge at a time. Scan faults can also be seen on `scan_out` after at most W edges.

// File: rtl/bilbo_reg.sv
module bilbo_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] par_in,
  input  logic         scan_in,
  output logic [W-1:0] par_out,
  output logic         scan_out
);
  localparam logic [1:0] M_SCAN = 2'b00;
  localparam logic [1:0] M_CLR  = 2'b01;
  localparam logic [1:0] M_SIG  = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [W-1:0] q;
  logic         fb;
  logic         head;

  assign fb       = ^(q & TAPS);
  assign head     = (mode == M_SCAN) ? scan_in : (par_in[0] ^ fb);
  assign par_out  = q;
  assign scan_out = q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (mode)
        M_SCAN:  q <= {q[W-2:0], head};
        M_CLR:   q <= '0;
        M_SIG:   q <= {par_in[W-1:1] ^ q[W-2:0], head};
        default: q <= par_in;
      endcase
    end
  end

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SCAN) |=> (par_out[0] == $past(scan_in)) && (par_out[W-1:1] == $past(par_out[W-2:0])));
  a_r3_serial_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SCAN) |=> scan_out == $past(par_out[W-2]));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CLR) |=> par_out == '0);
  a_r5_sig_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SIG) |=> par_out[W-1:1] == $past(par_in[W-1:1] ^ par_out[W-2:0]));
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD) |=> par_out == $past(par_in));
  a_r8_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SIG && par_out == '0 && par_in == '0) |=> par_out == '0);
endmodule

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;
  localparam int W = 8;
  localparam logic [W-1:0] TAPS = 8'hB8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b11;
  logic [W-1:0] par_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] par_out;
  logic         scan_out;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] exp_q[$];
  int           tag_q[$];

  always #4 clk = ~clk;

  bilbo_reg #(.W(W), .TAPS(TAPS)) u_bilbo_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
    .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out));

  function automatic logic [W-1:0] next_state(logic [W-1:0] s, logic [1:0] m,
                                               logic [W-1:0] d, logic si);
    logic [W-1:0] n;
    logic f;
    f = 1'b0;
    for (int i = 0; i < W; i++) if (TAPS[i]) f = f ^ s[i];
    case (m)
      2'b00: n = {s[W-2:0], si};
      2'b01: n = '0;
      2'b10: begin
        n[0] = d[0] ^ f;
        for (int i = 1; i < W; i++) n[i] = d[i] ^ s[i-1];
      end
      default: n = d;
    endcase
    return n;
  endfunction

  task automatic check(input bit ok, input int req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [W-1:0] d, input logic si, input int req);
    @(negedge clk);
    mode = m; par_in = d; scan_in = si;
    model = next_state(model, m, d, si);
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      int t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(par_out == e, t, par_out, e);
      check(scan_out == e[W-1], 3, {7'd0, scan_out}, {7'd0, e[W-1]});
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R0 watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] seed;
    int first_ret;
    repeat (3) @(negedge clk);
    check(par_out == '0 && scan_out == 1'b0, 1, par_out, '0);  // R1
    rst_n = 1'b1;

    drive(2'b11, 8'hA5, 1'b1, 7);   // R7
    drive(2'b11, 8'h3C, 1'b0, 7);
    drive(2'b01, 8'hFF, 1'b1, 4);   // R4
    drive(2'b11, 8'h81, 1'b0, 8);   // R8: mode change, then scan from loaded value
    for (int i = 0; i < W + 2; i++) drive(2'b00, 8'h00, i[0], 2);  // R2, R3
    drive(2'b10, 8'h5A, 1'b0, 8);   // R8: signature right after scan
    for (int i = 0; i < 12; i++) drive(2'b10, 8'h11 * i[3:0], 1'b1, 5);  // R5
    drive(2'b01, 8'h00, 1'b0, 4);
    for (int i = 0; i < 4; i++) drive(2'b10, 8'h00, 1'b1, 8);  // R8 zero lock
    drive(2'b11, 8'hFF, 1'b0, 7);
    for (int i = 0; i < 3; i++) drive(2'b01, 8'hC3, 1'b1, 4);

    seed = 8'h01;
    drive(2'b11, seed, 1'b0, 7);
    first_ret = 0;
    for (int i = 1; i <= 300; i++) begin
      drive(2'b10, 8'h00, 1'b0, 6);  // R6
      if (first_ret == 0 && model == seed) first_ret = i;
    end
    @(negedge clk);
    @(negedge clk);
    check(first_ret == 255, 6, first_ret[W-1:0], 8'hFF);  // R6 period

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule